// File: doc/BRIEF.md
# Operand Stack Unit with In-Place Add

This block is the operand stack of a zero-address datapath. It keeps a stack pointer register and a small single-port RAM that holds the stack. Commands arrive on a valid/ready port: push stores a word, pop returns the top word, and add replaces the two top words with their sum. Each finished command raises a one-cycle `done` pulse. A command that cannot run raises `err` with its `done`.

Push stores at the address in the pointer and then moves the pointer up by one. Pop first moves the pointer down and then reads the word it now points at. Add takes three RAM cycles: a read of the top word, a read of the word below it, and a write of the sum over the lower operand. The pointer drops by one when the write is made.

Back-pressure: a command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. While a pop or an add is in progress, `cmd_ready` is low and `busy` is high. The source must then hold its command stable until it is taken. Results have no back-pressure: `rd_data` and `carry` hold their values until a later pop or add changes them.

Top module: `opstack_unit`

## Requirements
- R1: After reset the stack is empty: `empty`=1, `full`=0, `cmd_ready`=1, `busy`=0, `done`=0, `err`=0, `rd_data`=0 and `carry`=0.
- R2: A push (`cmd_op`=2'b01) on a stack that is not full stores `cmd_wdata` on top and raises depth by one. `done` is high in the cycle after acceptance, and `cmd_ready` stays high.
- R3: A pop (`cmd_op`=2'b10) on a non-empty stack returns the most recently pushed word that has not yet been removed. The word appears on `rd_data`, together with `done`, two cycles after acceptance, and depth drops by one.
- R4: An add (`cmd_op`=2'b11) with at least two entries removes the two top words and pushes their sum, so depth drops by one. `done` is high, and `rd_data` shows the sum, three cycles after acceptance.
- R5: The sum wraps modulo 2^DW. `carry` takes the carry-out of each accepted add and keeps its value through every other command.
- R6: A push while full is rejected: `done` and `err` are high in the cycle after acceptance, and depth and stack contents are unchanged.
- R7: A pop while empty, an add with fewer than two entries, and the code 2'b00 are rejected in the same way as R6, with no change to the stack.
- R8: `cmd_ready` is low and `busy` is high from the cycle after a pop or add is accepted until its `done` cycle. No command is taken while `cmd_ready` is low.
- R9: `empty` is high exactly when depth is 0, and `full` is high exactly when depth equals DEPTH.
- R10: `err` is never high without `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit can take a command this cycle |
| cmd_op | input | 2 | 00 none, 01 push, 10 pop, 11 add |
| cmd_wdata | input | DW | Word to push |
| done | output | 1 | Command finished (one cycle) |
| err | output | 1 | Command rejected (with done) |
| rd_data | output | DW | Last popped word or last sum |
| carry | output | 1 | Carry-out of the last add |
| busy | output | 1 | Multi-cycle command in progress |
| empty | output | 1 | Stack depth is zero |
| full | output | 1 | Stack depth is DEPTH |

## Verification
After the accepting edge, the `done` pulse follows one cycle later for push and for a rejected command, two cycles later for pop, and three cycles later for add. The flags move at the accepting edge for push and pop, and at the final write for add. The bench reference model steps a queue in time with the clock on each rising edge and counts these latencies down itself. It compares every output on the falling edge, so each result is checked in the exact cycle it is due and in no other. Stimulus offers a new command while the unit is busy, so the ready rule is checked under back-pressure.

// File: rtl/opstack_pkg.sv
package opstack_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_ADD  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_POP  = 2'b01,
    ST_ADD1 = 2'b10,
    ST_ADD2 = 2'b11
  } st_e;
endpackage

// File: rtl/opstack_ram.sv
module opstack_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end

  AST_WRITE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> en); // R4
endmodule

// File: rtl/opstack_ptr.sv
module opstack_ptr #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] sp,
  output logic          empty,
  output logic          full,
  output logic          two_plus
);
  localparam logic [CW-1:0] LIMIT = CW'(DEPTH);
  localparam logic [CW-1:0] TWO   = CW'(2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sp <= '0;
    else if (inc) sp <= sp + CW'(1);
    else if (dec) sp <= sp - CW'(1);
  end

  assign empty    = (sp == '0);
  assign full     = (sp == LIMIT);
  assign two_plus = (sp >= TWO);

  AST_SP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= LIMIT); // R9
  AST_SP_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sp != $past(sp)) |-> ((sp == $past(sp) + CW'(1)) || (sp == $past(sp) - CW'(1)))); // R2
endmodule

// File: rtl/opstack_seq.sv
module opstack_seq
  import opstack_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [DW-1:0] cmd_wdata,
  input  logic [CW-1:0] sp,
  input  logic          empty,
  input  logic          full,
  input  logic          two_plus,
  input  logic [DW-1:0] ram_rdata,
  output logic          cmd_ready,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] rd_data,
  output logic          carry,
  output logic          ram_en,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  output logic          sp_inc,
  output logic          sp_dec
);
  st_e           state, state_n;
  op_e           op;
  logic [DW-1:0] opa;
  logic [DW:0]   sum;
  logic [CW-1:0] spm1, spm2;
  logic          reject, fire;

  assign op        = op_e'(cmd_op);
  assign spm1      = sp - CW'(1);
  assign spm2      = sp - CW'(2);
  assign sum       = {1'b0, opa} + {1'b0, ram_rdata};
  assign cmd_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign fire      = cmd_valid && cmd_ready;

  always_comb begin
    unique case (op)
      OP_PUSH: reject = full;
      OP_POP:  reject = empty;
      OP_ADD:  reject = !two_plus;
      default: reject = 1'b1;
    endcase
  end

  always_comb begin
    state_n   = state;
    ram_en    = 1'b0;
    ram_we    = 1'b0;
    ram_addr  = '0;
    ram_wdata = sum[DW-1:0];
    sp_inc    = 1'b0;
    sp_dec    = 1'b0;
    unique case (state)
      ST_IDLE: if (fire && !reject) begin
        unique case (op)
          OP_PUSH: begin
            ram_en    = 1'b1;
            ram_we    = 1'b1;
            ram_addr  = sp[AW-1:0];
            ram_wdata = cmd_wdata;
            sp_inc    = 1'b1;
          end
          OP_POP: begin
            ram_en   = 1'b1;
            ram_addr = spm1[AW-1:0];
            sp_dec   = 1'b1;
            state_n  = ST_POP;
          end
          OP_ADD: begin
            ram_en   = 1'b1;
            ram_addr = spm1[AW-1:0];
            state_n  = ST_ADD1;
          end
          default: ;
        endcase
      end
      ST_POP: state_n = ST_IDLE;
      ST_ADD1: begin
        ram_en   = 1'b1;
        ram_addr = spm2[AW-1:0];
        state_n  = ST_ADD2;
      end
      ST_ADD2: begin
        ram_en   = 1'b1;
        ram_we   = 1'b1;
        ram_addr = spm2[AW-1:0];
        sp_dec   = 1'b1;
        state_n  = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      done    <= 1'b0;
      err     <= 1'b0;
      rd_data <= '0;
      carry   <= 1'b0;
      opa     <= '0;
    end else begin
      state <= state_n;
      done  <= 1'b0;
      err   <= 1'b0;
      unique case (state)
        ST_IDLE: if (fire) begin
          if (reject) begin
            done <= 1'b1;
            err  <= 1'b1;
          end else if (op == OP_PUSH) begin
            done <= 1'b1;
          end
        end
        ST_POP: begin
          done    <= 1'b1;
          rd_data <= ram_rdata;
        end
        ST_ADD1: opa <= ram_rdata;
        ST_ADD2: begin
          done    <= 1'b1;
          rd_data <= sum[DW-1:0];
          carry   <= sum[DW];
        end
        default: ;
      endcase
    end
  end

  AST_FULL_PUSH_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == OP_PUSH && full) |=> (err && done)); // R6
  AST_ADD_HOLDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == OP_ADD && two_plus) |=> (busy && !done)); // R8
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done); // R10
endmodule

// File: rtl/opstack_unit.sv
module opstack_unit #(
  parameter int DW    = 8,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [DW-1:0] cmd_wdata,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] rd_data,
  output logic          carry,
  output logic          busy,
  output logic          empty,
  output logic          full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] sp;
  logic          two_plus, sp_inc, sp_dec;
  logic          ram_en, ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata, ram_rdata;

  opstack_ptr #(.DEPTH(DEPTH)) i_ptr (
    .clk(clk), .rst_n(rst_n), .inc(sp_inc), .dec(sp_dec),
    .sp(sp), .empty(empty), .full(full), .two_plus(two_plus)
  );

  opstack_ram #(.DW(DW), .DEPTH(DEPTH)) i_ram (
    .clk(clk), .rst_n(rst_n), .en(ram_en), .we(ram_we),
    .addr(ram_addr), .wdata(ram_wdata), .rdata(ram_rdata)
  );

  opstack_seq #(.DW(DW), .DEPTH(DEPTH)) i_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_wdata(cmd_wdata), .sp(sp), .empty(empty), .full(full),
    .two_plus(two_plus), .ram_rdata(ram_rdata), .cmd_ready(cmd_ready),
    .busy(busy), .done(done), .err(err), .rd_data(rd_data), .carry(carry),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .sp_inc(sp_inc), .sp_dec(sp_dec)
  );
endmodule

// File: tb/test_opstack_unit.sv
module test_opstack_unit;
  localparam int DW    = 8;
  localparam int DEPTH = 8;
  localparam int MASK  = (1 << DW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = 2'b00;
  logic [DW-1:0] cmd_wdata = '0;
  logic          cmd_ready, done, err, carry, busy, empty, full;
  logic [DW-1:0] rd_data;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  opstack_unit #(.DW(DW), .DEPTH(DEPTH)) i_opstack_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .done(done), .err(err),
    .rd_data(rd_data), .carry(carry), .busy(busy), .empty(empty), .full(full)
  );

  // Reference model: a queue stepped on each rising edge
  int    stk[$];
  int    phase = 0;
  int    pend = 0;
  int    pend_c = 0;
  bit    pend_add = 0;
  bit    m_done = 0, m_err = 0, m_carry = 0;
  int    m_rd = 0;
  string rd_tag = "R1";
  string err_tag = "R1";

  always @(posedge clk) begin
    m_done = 0;
    m_err  = 0;
    if (!rst_n) begin
      stk.delete();
      phase = 0; m_rd = 0; m_carry = 0;
      rd_tag = "R1"; err_tag = "R1";
    end else if (phase > 0) begin
      phase--;
      if (phase == 0) begin
        m_done = 1;
        m_rd   = pend;
        if (pend_add) begin
          void'(stk.pop_back());
          void'(stk.pop_back());
          stk.push_back(pend);
          m_carry = (pend_c != 0);
          rd_tag  = "R4";
        end else begin
          rd_tag = "R3";
        end
      end
    end else if (cmd_valid) begin
      case (cmd_op)
        2'b01: if (stk.size() == DEPTH) begin
                 m_done = 1; m_err = 1; err_tag = "R6";
               end else begin
                 stk.push_back(int'(cmd_wdata)); m_done = 1; err_tag = "R2";
               end
        2'b10: if (stk.size() == 0) begin
                 m_done = 1; m_err = 1; err_tag = "R7";
               end else begin
                 pend = stk.pop_back(); pend_add = 0; phase = 1; err_tag = "R3";
               end
        2'b11: if (stk.size() < 2) begin
                 m_done = 1; m_err = 1; err_tag = "R7";
               end else begin
                 pend     = (stk[stk.size()-1] + stk[stk.size()-2]) & MASK;
                 pend_c   = (stk[stk.size()-1] + stk[stk.size()-2]) >> DW;
                 pend_add = 1; phase = 2; err_tag = "R4";
               end
        default: begin m_done = 1; m_err = 1; err_tag = "R7"; end
      endcase
    end
  end

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Compare every output on every falling edge
  always @(negedge clk) begin
    cmp("R8",  "cmd_ready", int'(cmd_ready), int'(phase == 0));
    cmp("R8",  "busy",      int'(busy),      int'(phase != 0));
    cmp("R10", "done",      int'(done),      int'(m_done));
    cmp(err_tag, "err",     int'(err),       int'(m_err));
    cmp("R9",  "empty",     int'(empty),     int'(stk.size() == 0));
    cmp("R9",  "full",      int'(full),      int'(stk.size() == DEPTH));
    cmp(rd_tag, "rd_data",  int'(rd_data),   m_rd);
    cmp("R5",  "carry",     int'(carry),     int'(m_carry));
  end

  task automatic issue(input logic [1:0] op, input int d);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_wdata = DW'(d);
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic rest(input int n);
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cmp("R1", "reset empty", int'(empty), 1);
    cmp("R1", "reset ready", int'(cmd_ready), 1);
    rst_n = 1'b1;
    rest(2);
    // R2 R3 LIFO order with a back-to-back stream
    issue(2'b01, 11); issue(2'b01, 22); issue(2'b01, 33);
    issue(2'b10, 0);  issue(2'b10, 0);
    rest(3);
    cmp("R3", "second pop word", int'(rd_data), 22);
    // R4 add and R5 wrap with carry
    issue(2'b01, 200); issue(2'b01, 100); issue(2'b11, 0);
    rest(4);
    cmp("R5", "wrapped sum", int'(rd_data), 44);
    cmp("R5", "carry set", int'(carry), 1);
    issue(2'b11, 0); rest(4);
    cmp("R4", "sum 11+44", int'(rd_data), 55);
    cmp("R5", "carry clear", int'(carry), 0);
    // R7 add with one entry, pop to empty, pop when empty, code 00
    issue(2'b11, 0); issue(2'b10, 0); issue(2'b10, 0); issue(2'b00, 0);
    rest(3);
    // R6 fill then push while full
    for (int k = 0; k < DEPTH; k++) issue(2'b01, k * 17 + 3);
    issue(2'b01, 99);
    rest(2);
    cmp("R9", "full flag", int'(full), 1);
    issue(2'b10, 0); rest(3);
    cmp("R6", "top survives reject", int'(rd_data), (DEPTH - 1) * 17 + 3);
    // Mixed stream, held valid exercises R8 back-pressure
    for (int k = 0; k < 600; k++) begin
      issue(2'($urandom_range(0, 3)), int'($urandom_range(0, MASK)));
      if ($urandom_range(0, 3) == 0) rest(int'($urandom_range(0, 2)));
    end
    rest(5);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule